// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is a bank of clocked registers placed between a memory controller and a memory rank. It carries address and command bits. A parameterised data bus is captured on a rising clock edge only while the rank is addressed, meaning at least one of two active-low select lines is low. When both select lines are high, the registered data keeps its value.

A few control lines are registered on every rising edge, whether or not the rank is addressed:

- a copy of the first select line,
- the on-die termination enables,
- the clock-enable lines.

An active-low reset clears all outputs at once, without waiting for a clock edge. Reset release is synchronised inside the block, so the first rising edge after release captures nothing. Captures start on the second edge.

Every pin is plain. There is no handshake and no back-pressure: the block takes a new value on each qualifying edge, and the consumer samples the outputs on the following edge.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: While `rst_n` is low, `dout`, `cs_q`, `odt_q` and `cke_q` are all zero, including before any clock edge.
- R2: On a rising edge in run state where `sel0_n` is low or `sel1_n` is low (or both are low), `dout` takes the value of `din`.
- R3: On a rising edge in run state where both `sel0_n` and `sel1_n` are high, `dout` keeps its previous value.
- R4: On every rising edge in run state, `odt_q` takes `odt_in` and `cke_q` takes `cke_in`, whatever the select lines are.
- R5: On every rising edge in run state, `cs_q` takes `sel0_n`. `sel1_n` has no effect on `cs_q`.
- R6: After `rst_n` rises, the first rising edge captures nothing and every output stays zero. Run state begins at the second edge.
- R7: Between rising edges, no output changes while `rst_n` stays high, even when the inputs change.
- R8: The width of `din` and `dout` is the parameter `DATA_W`, which defaults to 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| sel0_n | input | 1 | First active-low select |
| sel1_n | input | 1 | Second active-low select |
| din | input | DATA_W | Address/command data in |
| odt_in | input | ODT_W | Termination enables in |
| cke_in | input | CKE_W | Clock enables in |
| dout | output | DATA_W | Registered data |
| cs_q | output | 1 | Registered copy of `sel0_n` |
| odt_q | output | ODT_W | Registered termination enables |
| cke_q | output | CKE_W | Registered clock enables |

## Verification
Two situations are hard to reach from the ports.

The first is the edge just after reset release. There the inputs must be set up to capture: selects low, non-zero data and control values. Every output must still read zero. The bench drops reset in the middle of a cycle with exactly such inputs applied. It releases reset with them still present, then checks the outputs after the first edge and again after the second.

The second is asynchronous clearing. The outputs are checked a fraction of a cycle after reset falls, before any edge can mask the effect. Deselected cycles are also preceded by a capture of a distinct pattern, so that holding cannot be confused with capturing.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int unsigned DEF_DATA_W = 25;
  localparam int unsigned DEF_ODT_W  = 1;
  localparam int unsigned DEF_CKE_W  = 1;

  // Rank is addressed when either active-low select is low.
  function automatic logic rank_addressed(input logic s0_n, input logic s1_n);
    return !(s0_n && s1_n);
  endfunction
endpackage

// File: rtl/cmdreg_run_gen.sv
module cmdreg_run_gen (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  // Clears at once with reset, sets on the first edge after release,
  // so that edge itself still sees run low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= 1'b1;
  end

  a_r6_run_rises_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> run);
endmodule

// File: rtl/cmdreg_data_bank.sv
module cmdreg_data_bank #(
  parameter int unsigned W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         addr_hit,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic cap;
  assign cap = run && addr_hit;

  for (genvar b = 0; b < W; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[b] <= 1'b0;
      else if (cap) q[b] <= d[b];
    end
  end

  a_r2_capture_when_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (run && addr_hit) |=> (q == $past(d)));
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !addr_hit) |=> $stable(q));
endmodule

// File: rtl/cmdreg_ctrl_bank.sv
module cmdreg_ctrl_bank #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (run) q <= d;
  end

  a_r4_ctrl_follows: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (q == $past(d)));
endmodule

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg
  import cmdreg_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ODT_W  = DEF_ODT_W,
  parameter int unsigned CKE_W  = DEF_CKE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic [DATA_W-1:0] din,
  input  logic [ODT_W-1:0]  odt_in,
  input  logic [CKE_W-1:0]  cke_in,
  output logic [DATA_W-1:0] dout,
  output logic              cs_q,
  output logic [ODT_W-1:0]  odt_q,
  output logic [CKE_W-1:0]  cke_q
);
  localparam int unsigned CTRL_W = 1 + ODT_W + CKE_W;

  logic              run;
  logic              hit;
  logic [CTRL_W-1:0] ctrl_d;
  logic [CTRL_W-1:0] ctrl_q;

  assign hit    = rank_addressed(sel0_n, sel1_n);
  assign ctrl_d = {sel0_n, odt_in, cke_in};

  cmdreg_run_gen u_run (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run)
  );

  cmdreg_data_bank #(.W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .addr_hit(hit),
    .d       (din),
    .q       (dout)
  );

  cmdreg_ctrl_bank #(.W(CTRL_W)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .d    (ctrl_d),
    .q    (ctrl_q)
  );

  assign cs_q  = ctrl_q[CTRL_W-1];
  assign odt_q = ctrl_q[CKE_W +: ODT_W];
  assign cke_q = ctrl_q[CKE_W-1:0];

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |-> (dout == '0 && !cs_q && odt_q == '0 && cke_q == '0));
  a_r5_cs_copy: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cs_q == $past(sel0_n)));
  a_r6_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (dout == '0 && !cs_q && odt_q == '0 && cke_q == '0));
endmodule

// File: tb/test_cs_gated_cmd_reg.sv
module test_cs_gated_cmd_reg;
  localparam int DW = 25;
  localparam int VW = DW + 4;
  localparam int NV = 10;
  // Vector: {sel0_n, sel1_n, odt, cke, din}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 25'h1ABCDEF},
    {1'b1, 1'b1, 1'b0, 1'b1, 25'h0555555},
    {1'b1, 1'b0, 1'b1, 1'b1, 25'h0F0F0F0},
    {1'b1, 1'b1, 1'b1, 1'b0, 25'h1FFFFFF},
    {1'b0, 1'b0, 1'b0, 1'b0, 25'h1000001},
    {1'b1, 1'b1, 1'b0, 1'b0, 25'h0000000},
    {1'b0, 1'b1, 1'b1, 1'b1, 25'h1FFFFFF},
    {1'b1, 1'b0, 1'b0, 1'b1, 25'h0AAAAAA},
    {1'b1, 1'b1, 1'b1, 1'b1, 25'h1234567},
    {1'b1, 1'b1, 1'b0, 1'b0, 25'h0000001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic sel0_n = 1'b1, sel1_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [0:0] odt_in = '0, cke_in = '0;
  logic [DW-1:0] dout;
  logic cs_q;
  logic [0:0] odt_q, cke_q;

  int checks = 0, errors = 0;
  logic [DW-1:0] e_d = '0;
  logic e_cs = 1'b0, e_odt = 1'b0, e_cke = 1'b0;

  always #2.5 clk = ~clk;

  cs_gated_cmd_reg i_cs_gated_cmd_reg (
    .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
    .din(din), .odt_in(odt_in), .cke_in(cke_in),
    .dout(dout), .cs_q(cs_q), .odt_q(odt_q), .cke_q(cke_q)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " dout"}, 64'(dout), 64'(e_d));
    chk({req, " cs_q"}, 64'(cs_q), 64'(e_cs));
    chk({req, " odt_q"}, 64'(odt_q), 64'(e_odt));
    chk({req, " cke_q"}, 64'(cke_q), 64'(e_cke));
  endtask

  task automatic apply(input logic [VW-1:0] v);
    @(negedge clk);
    {sel0_n, sel1_n, odt_in, cke_in, din} = v;
  endtask

  // Model of one run-state edge (R2..R5).
  task automatic model_edge();
    if (!sel0_n || !sel1_n) e_d = din;
    e_cs = sel0_n; e_odt = odt_in[0]; e_cke = cke_in[0];
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #0.5;
    chk_all("R1 async clear before first edge");
    repeat (2) @(posedge clk);
    #1 chk_all("R1 reset held over edges");
    // Release with capture-ready inputs: R6.
    apply({1'b0, 1'b0, 1'b1, 1'b1, 25'h1CAFE11});
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk_all("R6 first edge after release quiet");
    @(posedge clk); #1;
    model_edge();
    chk_all("R6 second edge captures");
    // Table walk: R2 R3 R4 R5.
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      #0.5 chk_all("R7 stable between edges");
      @(posedge clk); #1;
      model_edge();
      chk_all($sformatf("R2/R3/R4/R5 vector %0d", i));
    end
    // R5: sel1_n alone must not touch cs_q.
    apply({1'b0, 1'b1, 1'b0, 1'b0, 25'h0000042});
    @(posedge clk); #1; model_edge();
    apply({1'b0, 1'b0, 1'b0, 1'b0, 25'h0000043});
    @(posedge clk); #1; model_edge();
    chk("R5 cs_q ignores sel1_n", 64'(cs_q), 64'(1'b0));
    // R7: inputs change mid-cycle, outputs hold.
    @(negedge clk);
    din = 25'h1FFFFFF; odt_in = 1'b1; cke_in = 1'b1; sel0_n = 1'b1;
    #1 chk_all("R7 no edge no change");
    @(posedge clk); #1; model_edge();
    chk_all("R4 capture after mid-cycle change");
    // R1 mid-cycle async assert with nonzero outputs.
    #0.5 rst_n = 1'b0;
    e_d = '0; e_cs = 1'b0; e_odt = 1'b0; e_cke = 1'b0;
    #0.5 chk_all("R1 async clear mid-cycle");
    chk("R8 data width", 64'($bits(dout)), 64'(25));
    @(negedge clk); rst_n = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule